// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block drives one pulse-width-modulated output. The output frequency comes from a 16-bit phase accumulator. On every clock while the generator runs, a programmable increment is added to the accumulator, modulo 65536. The output frequency is therefore increment × f_clk / 65536. The duty cycle comes from an 8-bit threshold compared against the accumulator's upper byte. The output is high while that byte is at or above the threshold, so a smaller threshold gives a wider pulse.

Software uses a single 32-bit control word, written with a one-cycle write strobe and read back at any time. Writes land in a staging copy. The values the generator uses live in a separate active copy, which is filled in two ways. Turning the generator on copies staging into active at once. While the generator runs, setting the update-request bit causes the copy at the next accumulator wrap; the request bit then clears itself. A sequencer with three states controls these copies:
- OFF: disabled. The accumulator is held at zero and the output is low.
- RUN: generating, with no copy pending.
- ARMED: generating, with a copy waiting for the wrap.

Its transitions are:
- OFF→RUN when enable is seen. Staging is loaded into active and the request is cleared.
- RUN→ARMED when a request is seen.
- ARMED→RUN on a wrap. Staging is loaded and the request is cleared.
- RUN→OFF and ARMED→OFF when enable is clear.

Top module: `phase_pwm`

## Requirements
- R1: A synchronous active-low reset clears the control word, the accumulator, the sequencer (to OFF) and the output. After reset `rd_data` reads 0 and `pwm_out` is 0.
- R2: Control word layout:
  - bit 31: enable
  - bit 30: update request
  - bits 23:8: increment
  - bits 7:0: duty threshold
  - bits 29:24: read as zero

  A write updates the staging copy. A read returns the staging fields, the enable bit and the live request bit.
- R3: While running, the accumulator advances by the active increment every clock, modulo 65536. Starting from the first running cycle (sample 0), sample k sees accumulator value (k × increment) mod 65536.
- R4: While enabled and running, `pwm_out` is 1 exactly when the accumulator's upper byte is at or above the active threshold. A threshold of 0 gives a constant 1; a threshold of 255 gives one high cycle in 256 at increment 0x0100.
- R5: When enable is written 1 while the sequencer is OFF, the next clock copies staging into active, clears the request bit and starts counting from 0.
- R6: A write made while running with the request bit 0 changes only the staging copy. The output pattern keeps following the old active values, including across wraps.
- R7: A write with the request bit 1 made while running leaves the active values untouched until the clock at which the accumulator carries past 0xFFFF. At that clock the staging values become active and the request bit reads 0 from then on.
- R8: Writing enable 0 drives `pwm_out` low from the next sample. The sequencer returns to OFF and the accumulator returns to 0, so a later enable starts again from phase 0.
- R9: Every increment value is handled: 0 freezes the accumulator, and values above 0x8002, up to 0xFFFF, still wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back |
| pwm_out | output | 1 | PWM output |

## Verification
The bench checks that a write with the request bit set is held off until the accumulator carries. A design that applied the new threshold immediately would turn the output fully on twelve cycles early. A design that ignored the request would never turn it fully on. Writes with the request bit clear are run across two wraps, which catches a design that copies staging to active on every wrap. Re-enabling with a threshold of 1 catches an accumulator that is not cleared on disable, because the first sample would then be high instead of low. Increments of 0, 0x8002 and 0xFFFF, with thresholds of 0 and 255, test the comparison and modulo boundaries where an off-by-one compare or a saturating adder would show.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;

    localparam int REG_W   = 32;
    localparam int ACC_W   = 16;
    localparam int DUTY_W  = 8;
    localparam int EN_BIT  = 31;
    localparam int REQ_BIT = 30;
    localparam int INC_LO  = DUTY_W;
    localparam int INC_HI  = INC_LO + ACC_W - 1;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/phase_pwm_regs.sv
module phase_pwm_regs
    import phase_pwm_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ACC_W,
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    input  logic          clr_req,
    output logic          en_q,
    output logic          req_q,
    output logic [AW-1:0] stage_inc,
    output logic [DW-1:0] stage_thr,
    output logic [RW-1:0] rd_data
);

    localparam int ILO = DW;
    localparam int IHI = DW + AW - 1;
    localparam int GAP = RW - 2 - AW - DW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            req_q     <= 1'b0;
            stage_inc <= '0;
            stage_thr <= '0;
        end else if (wr_en) begin
            en_q      <= wr_data[RW-1];
            req_q     <= wr_data[RW-2];
            stage_inc <= wr_data[IHI:ILO];
            stage_thr <= wr_data[DW-1:0];
        end else if (clr_req) begin
            req_q     <= 1'b0;
        end
    end

    always_comb begin
        rd_data = {en_q, req_q, {GAP{1'b0}}, stage_inc, stage_thr};
    end

endmodule

// File: rtl/phase_pwm_fsm.sv
module phase_pwm_fsm
    import phase_pwm_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_q,
    input  logic          req_q,
    input  logic          wrap,
    input  logic [AW-1:0] stage_inc,
    input  logic [DW-1:0] stage_thr,
    output pwm_state_e    state_q,
    output logic          run,
    output logic          clr_req,
    output logic [AW-1:0] act_inc,
    output logic [DW-1:0] act_thr
);

    pwm_state_e state_d;
    logic       load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            act_inc <= '0;
            act_thr <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                act_inc <= stage_inc;
                act_thr <= stage_thr;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en_q) begin
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en_q)      state_d = ST_OFF;
                else if (req_q) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                end else if (wrap) begin
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        run     = (state_q != ST_OFF);
        clr_req = load;
    end

endmodule

// File: rtl/phase_pwm_accum.sv
module phase_pwm_accum #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en_q,
    input  logic [AW-1:0] act_inc,
    input  logic [DW-1:0] act_thr,
    output logic          wrap,
    output logic          pwm_out
);

    logic [AW-1:0] acc_q;
    logic [AW:0]   sum;

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, act_inc};
        wrap = run && sum[AW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) acc_q <= '0;
        else                acc_q <= sum[AW-1:0];
    end

    always_comb begin
        pwm_out = run && en_q && (acc_q[AW-1 -: DW] >= act_thr);
    end

endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
    import phase_pwm_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ACC_W,
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    output logic          pwm_out
);

    pwm_state_e    state_q;
    logic          en_q, req_q, clr_req, run, wrap;
    logic [AW-1:0] stage_inc, act_inc;
    logic [DW-1:0] stage_thr, act_thr;

    phase_pwm_regs #(.RW(RW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clr_req(clr_req), .en_q(en_q), .req_q(req_q),
        .stage_inc(stage_inc), .stage_thr(stage_thr), .rd_data(rd_data)
    );

    phase_pwm_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_q(en_q), .req_q(req_q), .wrap(wrap),
        .stage_inc(stage_inc), .stage_thr(stage_thr), .state_q(state_q),
        .run(run), .clr_req(clr_req), .act_inc(act_inc), .act_thr(act_thr)
    );

    phase_pwm_accum #(.AW(AW), .DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(run), .en_q(en_q),
        .act_inc(act_inc), .act_thr(act_thr), .wrap(wrap), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk
    import phase_pwm_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ACC_W,
    parameter int DW = DUTY_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [RW-1:0] wr_data,
    input logic [RW-1:0] rd_data,
    input logic          pwm_out,
    input pwm_state_e    state_q,
    input logic          wrap,
    input logic          req_q,
    input logic [AW-1:0] stage_inc,
    input logic [DW-1:0] stage_thr,
    input logic [AW-1:0] act_inc,
    input logic [DW-1:0] act_thr
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == '0 && !pwm_out));

    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !pwm_out);

    p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && rd_data[RW-1] && !wr_en) |=>
        (act_inc == $past(stage_inc) && act_thr == $past(stage_thr)));

    p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ($stable(act_inc) && $stable(act_thr)));

    p_armed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !wrap) |=> ($stable(act_inc) && $stable(act_thr)));

    p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && wrap && rd_data[RW-1] && !wr_en) |=> !req_q);

endmodule

bind phase_pwm phase_pwm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out), .state_q(state_q), .wrap(wrap),
    .req_q(req_q), .stage_inc(stage_inc), .stage_thr(stage_thr),
    .act_inc(act_inc), .act_thr(act_thr)
);

// File: tb/phase_pwm_bench.sv
`timescale 1ns/1ps
module phase_pwm_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    phase_pwm u_phase_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // {increment[15:0], threshold[7:0], samples[15:0]}
    localparam logic [39:0] VEC [8] = '{
        {16'h0100, 8'h80, 16'd256},
        {16'h0100, 8'h00, 16'd256},
        {16'h0100, 8'hFF, 16'd256},
        {16'h0200, 8'h40, 16'd128},
        {16'h8002, 8'h10, 16'd64},
        {16'hFFFF, 8'h80, 16'd64},
        {16'h0000, 8'h00, 16'd8},
        {16'h0000, 8'h01, 16'd8}
    };

    function automatic logic [31:0] word(bit en, bit req, logic [15:0] inc, logic [7:0] thr);
        return {en, req, 6'b0, inc, thr};
    endfunction

    function automatic bit model_out(int k, int inc, int thr);
        return ((((k * inc) % 65536) / 256) >= thr);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int errs;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data == 32'h0, "R1 reset rd_data", rd_data, 32'h0);
        check(pwm_out == 1'b0, "R1 reset pwm_out", {31'b0, pwm_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: field layout read-back, bits 29:24 zero, live request bit
        bus_write(32'hFF12_3456);
        check(rd_data == 32'hC012_3456, "R2 read-back", rd_data, 32'hC012_3456);
        @(negedge clk);
        // R5: enable from OFF clears request
        check(rd_data == 32'h8012_3456, "R5 request cleared on enable", rd_data, 32'h8012_3456);

        // R3 R4 R9: vector walk
        foreach (VEC[v]) begin
            int inc, thr, n;
            inc = int'(VEC[v][39:24]);
            thr = int'(VEC[v][23:16]);
            n   = int'(VEC[v][15:0]);
            bus_write(32'h0);
            repeat (2) @(negedge clk);
            bus_write(word(1'b1, 1'b0, VEC[v][39:24], VEC[v][23:16]));
            @(negedge clk);
            errs = 0;
            for (int k = 0; k < n; k++) begin
                if (pwm_out != model_out(k, inc, thr)) errs++;
                @(negedge clk);
            end
            check(errs == 0, "R3 R4 R9 vector mismatches", errs, 0);
        end

        // R6 R7: staging-only write, then deferred update at wrap
        bus_write(32'h0);
        repeat (2) @(negedge clk);
        bus_write(word(1'b1, 1'b0, 16'h1000, 8'h80));
        @(negedge clk);
        begin
            int e6, e7a, e7b;
            bit req15, req16;
            e6 = 0; e7a = 0; e7b = 0; req15 = 0; req16 = 1;
            for (int k = 0; k < 64; k++) begin
                bit exp;
                exp = (k < 48) ? ((k % 16) >= 8) : 1'b1;
                if (pwm_out != exp) begin
                    if (k < 36) e6++;
                    else if (k < 48) e7a++;
                    else e7b++;
                end
                if (k == 47) req15 = rd_data[30];
                if (k == 48) req16 = rd_data[30];
                wr_en = (k == 3) || (k == 35);
                wr_data = word(1'b1, (k == 35), 16'h1000, 8'h00);
                @(negedge clk);
            end
            wr_en = 1'b0;
            check(e6 == 0, "R6 staging-only write changed output", e6, 0);
            check(e7a == 0, "R7 update applied before wrap", e7a, 0);
            check(e7b == 0, "R7 update not applied at wrap", e7b, 0);
            check(req15 == 1'b1, "R7 request pending before wrap", req15, 1);
            check(req16 == 1'b0, "R7 request self-clear at wrap", req16, 0);
        end

        // R8: disable then re-enable from phase 0
        bus_write(word(1'b0, 1'b0, 16'h0100, 8'h01));
        check(pwm_out == 1'b0, "R8 output low after disable", pwm_out, 0);
        repeat (3) @(negedge clk);
        bus_write(word(1'b1, 1'b0, 16'h0100, 8'h01));
        @(negedge clk);
        check(pwm_out == 1'b0, "R8 phase restarts at zero", pwm_out, 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R5 staging loaded on enable", pwm_out, 1);

        // R1: reset while running
        rst_n = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 mid-run reset pwm_out", pwm_out, 0);
        check(rd_data == 32'h0, "R1 mid-run reset rd_data", rd_data, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule